// File: doc/BRIEF.md
# Single-Port RAM with Selectable Write Modes

This block is a synchronous single-port memory with one clock. On a rising edge with the enable high, it either reads the addressed word or writes the input word. A write stores the word in the array. A parameter then decides what the data output shows on that write: the word just written, the word that was there before, or the unchanged previous output.

A synchronous set/reset loads a programmable constant into the output latch and leaves the array untouched. An optional output pipeline register adds one cycle of read latency. That register has its own clock enable and its own reset to the same constant.

Width, depth, write mode, reset constant and the presence of the pipeline register are all parameters. At simulation start the array is all zeros and the output holds the reset constant.

Top module: `spram_wm`

## Requirements
- R1: On an edge where `en` is 0, nothing happens: no read, no write and no reset. `dout` keeps its value, and the array keeps its contents whatever `we`, `srst`, `addr` and `din` carry.
- R2: An edge with `en`=1, `we`=0 and `srst`=0 puts the word stored at `addr` on the output latch, and the array is not changed.
- R3: With `WMODE`=0 (new data shown), an edge with `en`=1 and `we`=1 stores `din` at `addr` and puts `din` on the output latch.
- R4: With `WMODE`=1 (old data shown), a write stores `din`, and the output latch receives the word held at `addr` before that edge.
- R5: With `WMODE`=2 (output held), a write stores `din`, and the output latch keeps its previous value.
- R6: An edge with `en`=1 and `srst`=1 loads `RST_VAL` into the output latch. Array contents stay intact.
- R7: When `srst`=1 and `we`=1 occur on the same enabled edge, the array is still written, and the output latch takes `RST_VAL`.
- R8: With `OUT_REG`=1, `dout` is the output latch delayed by one further clock edge. Read data therefore appears one cycle later than with `OUT_REG`=0.
- R9: With `OUT_REG`=1, the output register updates only on edges where `oreg_ce`=1. On such an edge, `oreg_rst`=1 loads `RST_VAL` into it instead of the latch value. With `oreg_ce`=0, `oreg_rst` has no effect.
- R10: At simulation start every array word is 0, and the output latch and the output register hold `RST_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| en | input | 1 | Enable for read, write and latch reset |
| we | input | 1 | Write enable, sampled when `en`=1 |
| srst | input | 1 | Synchronous output-latch reset to `RST_VAL` |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| oreg_ce | input | 1 | Clock enable of the optional output register |
| oreg_rst | input | 1 | Synchronous reset of the optional output register |
| dout | output | DW | Read data |

## Verification
The bench runs four small instances side by side on the same stimulus: one for each write mode, plus one with the pipeline register. It sweeps every address with data patterns computed from the address.

A design that showed the wrong word on a write would fail the write sweeps in whichever mode it confused. An enable that was not honoured would either corrupt the array during the disabled sweep or move the output. A reset that touched memory, or that blocked a write on the same edge, would be caught when the address is read back afterwards. A pipeline with the wrong depth, or one that ignored its own enable or reset, would show up as output values one cycle off.

// File: rtl/spram_wm.sv
module spram_wm #(
  parameter int          DW      = 16,
  parameter int          AW      = 10,
  parameter int          WMODE   = 0,
  parameter bit          OUT_REG = 1'b0,
  parameter logic [DW-1:0] RST_VAL = DW'(16'h0101)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic          srst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          oreg_ce,
  input  logic          oreg_rst,
  output logic [DW-1:0] dout
);
  localparam int DEPTH    = 1 << AW;
  localparam int WR_FIRST = 0;
  localparam int RD_FIRST = 1;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] lat = RST_VAL;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= din;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (srst)                     lat <= RST_VAL;
      else if (!we)                 lat <= mem[addr];
      else if (WMODE == WR_FIRST)   lat <= din;
      else if (WMODE == RD_FIRST)   lat <= mem[addr];
    end
  end

  a_r1_disabled_hold: assert property (@(posedge clk) !en |=> $stable(lat));
  a_r2_read_word: assert property (@(posedge clk)
    en && !we && !srst |=> lat == $past(mem[addr]));
  a_r6_reset_value: assert property (@(posedge clk) en && srst |=> lat == RST_VAL);
  a_r7_write_under_reset: assert property (@(posedge clk)
    en && we && srst |=> mem[$past(addr)] == $past(din));

  if (WMODE == WR_FIRST) begin : g_wf
    a_r3_new_data: assert property (@(posedge clk)
      en && we && !srst |=> lat == $past(din));
  end else if (WMODE == RD_FIRST) begin : g_rf
    a_r4_old_data: assert property (@(posedge clk)
      en && we && !srst |=> lat == $past(mem[addr]));
  end else begin : g_nc
    a_r5_hold: assert property (@(posedge clk)
      en && we && !srst |=> $stable(lat));
  end

  if (OUT_REG) begin : g_pipe
    logic [DW-1:0] q = RST_VAL;
    always_ff @(posedge clk) begin
      if (oreg_ce) q <= oreg_rst ? RST_VAL : lat;
    end
    assign dout = q;
    a_r8_pipe_delay: assert property (@(posedge clk)
      oreg_ce && !oreg_rst |=> q == $past(lat));
    a_r9_pipe_gate: assert property (@(posedge clk) !oreg_ce |=> $stable(q));
  end else begin : g_flow
    logic unused_pipe_ctl;
    assign unused_pipe_ctl = oreg_ce ^ oreg_rst;
    assign dout = lat;
  end
endmodule

// File: tb/spram_wm_bench.sv
module spram_wm_bench;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] RV = 8'hA5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          en = 0, we = 0, srst = 0, oce = 0, orst = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] d_wf, d_rf, d_nc, d_pp;

  spram_wm #(.DW(DW), .AW(AW), .WMODE(0), .OUT_REG(1'b0), .RST_VAL(RV)) u_spram_wm (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din),
    .oreg_ce(oce), .oreg_rst(orst), .dout(d_wf));
  spram_wm #(.DW(DW), .AW(AW), .WMODE(1), .OUT_REG(1'b0), .RST_VAL(RV)) u_spram_wm_rf (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din),
    .oreg_ce(oce), .oreg_rst(orst), .dout(d_rf));
  spram_wm #(.DW(DW), .AW(AW), .WMODE(2), .OUT_REG(1'b0), .RST_VAL(RV)) u_spram_wm_nc (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din),
    .oreg_ce(oce), .oreg_rst(orst), .dout(d_nc));
  spram_wm #(.DW(DW), .AW(AW), .WMODE(0), .OUT_REG(1'b1), .RST_VAL(RV)) u_spram_wm_pp (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din),
    .oreg_ce(oce), .oreg_rst(orst), .dout(d_pp));

  int checks = 0, errors = 0, cycles = 0;
  logic [DW-1:0] m [DEPTH];
  logic [DW-1:0] e_wf = RV, e_rf = RV, e_nc = RV, e_pp = RV;

  task automatic chk(input string tag, input string who, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, who, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "new-data", d_wf, e_wf);
    chk(tag, "old-data", d_rf, e_rf);
    chk(tag, "hold", d_nc, e_nc);
    chk(tag, "pipelined", d_pp, e_pp);
  endtask

  task automatic step(input string tag, input logic i_en, input logic i_we, input logic i_sr,
                      input int a, input logic [DW-1:0] d, input logic i_oce, input logic i_orst);
    logic [DW-1:0] old;
    en = i_en; we = i_we; srst = i_sr; addr = AW'(a); din = d; oce = i_oce; orst = i_orst;
    @(posedge clk);
    old = m[a];
    if (i_oce) e_pp = i_orst ? RV : e_wf;
    if (i_en) begin
      if (i_sr) begin e_wf = RV; e_rf = RV; e_nc = RV; end
      else if (!i_we) begin e_wf = old; e_rf = old; e_nc = old; end
      else begin e_wf = d; e_rf = old; end
      if (i_we) m[a] = d;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual %0d expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m[i] = '0;
    #1;
    check_all("R10");
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) step("R10", 1, 0, 0, a, 8'h00, 1, 0);
    for (int a = 0; a < DEPTH; a++) step("R3 R4 R5 R8", 1, 1, 0, a, DW'(a*37+5), 1, 0);
    for (int a = 0; a < DEPTH; a++) step("R2 R8", 1, 0, 0, DEPTH-1-a, 8'h00, 1, 0);
    for (int a = 0; a < DEPTH; a++) step("R1", 0, 1, a[0], a, DW'(a*13+90), 1, 0);
    for (int a = 0; a < DEPTH; a++) step("R1", 1, 0, 0, a, 8'h00, 1, 0);
    step("R6", 1, 0, 1, 7, 8'h00, 1, 0);
    step("R6", 1, 0, 0, 7, 8'h00, 1, 0);
    step("R7", 1, 1, 1, 3, 8'h3C, 1, 0);
    step("R7", 1, 0, 0, 3, 8'h00, 1, 0);
    for (int a = 0; a < DEPTH; a++) step("R3 R4 R5", 1, 1, 0, a, DW'(a*11+200), 1, 0);
    for (int a = 0; a < DEPTH; a += 3) begin
      step("R3 R4 R5", 1, 1, 0, a, DW'(a*29+1), 1, 0);
      step("R2", 1, 0, 0, a, 8'h00, 1, 0);
    end
    step("R9", 1, 0, 0, 5, 8'h00, 0, 1);
    step("R9", 1, 0, 0, 6, 8'h00, 0, 0);
    step("R9", 1, 0, 0, 9, 8'h00, 1, 1);
    step("R9", 1, 0, 0, 10, 8'h00, 1, 0);
    step("R8", 1, 0, 0, 11, 8'h00, 1, 0);
    step("R8", 1, 0, 0, 12, 8'h00, 1, 0);
    finish_run();
  end
endmodule